// File: doc/BRIEF.md
# Ping-Pong Audio Output DMA

This block feeds an audio codec from two memory buffers that take turns. The codec pulls data: it asks for a number of bytes, and one cycle later the block answers with a memory address, a granted byte count and a flag that says whether more data follows. The block does not move any data itself. It only hands out address and length grants. When a buffer runs out, the block raises a drain flag for that buffer and moves on to the other one. The playback loop can only stop at the end of buffer 1.

The host sees one control/status byte. Writing it sets the two interrupt-enable bits and always clears both drain flags. Reading it returns the stored byte together with any drain flags set since the last write. A level interrupt is formed from the flags and their enables. The current position inside the active buffer is exported as a 24-bit phase word for readback.

Playback starts on a rising edge of the enable input. At that edge the block latches the base address and the sample count. Each buffer sits at a fixed offset from an aligned base address. Its length is four bytes (two channels of two bytes each) per programmed sample.

Top module: `pp_audio_dma`

## Requirements
- R1: After a synchronous active-low reset, the control byte reads 0x00, the interrupt output is low, the phase word is 0 and no response is valid.
- R2: A rising edge of `out_en` starts playback at buffer 0, position 0. On that edge the block latches `base_addr` with bits [17:0] cleared, and sets the buffer length to `sample_count` × 4 bytes. A request in the same cycle as the edge is answered with a zero-length grant and more-data low.
- R3: A request is answered in the next cycle (`resp_valid` high). The grant length is the smaller of the requested length and the bytes left in the active buffer. The address is the latched base plus the buffer offset (0x10000 for buffer 0, 0x12000 for buffer 1) plus the current position. The position then advances by the grant.
- R4: A request that finds the active buffer exhausted sets drain flag bit 6 if buffer 0 was active, or bit 7 if buffer 1 was active. Unless R5 applies, the request is then served from the start of the other buffer.
- R5: When buffer 1 is found exhausted while `out_en` is low, the block answers with length 0 and more-data low, resets the position and stops. Buffer 0 found exhausted while `out_en` is low still switches to buffer 1.
- R6: A request while playback is stopped gets a zero-length grant with more-data low and leaves the control byte unchanged.
- R7: A host write stores the byte with bits 7:6 forced to 0, and a read returns the stored byte with any flags set since. A drain flag set in the same cycle as a write is kept.
- R8: `irq` equals (bit6 AND bit4) OR (bit7 AND bit5) of the control byte.
- R9: The phase word carries the low 12 bits of the position in bits [17:6], with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| out_en | input | 1 | Playback enable; rising edge starts, low requests a stop at the end of buffer 1 |
| base_addr | input | 32 | Buffer base address, latched at start |
| sample_count | input | 10 | Samples per buffer, latched at start |
| host_wr | input | 1 | Control byte write strobe |
| host_wdata | input | 8 | Control byte write data |
| host_rdata | output | 8 | Control byte readback |
| irq | output | 1 | Level interrupt |
| pull_req | input | 1 | Codec data request |
| pull_len | input | 16 | Requested byte count |
| resp_valid | output | 1 | Response valid, one cycle after request |
| resp_addr | output | 32 | Granted memory address |
| resp_len | output | 16 | Granted byte count |
| resp_more | output | 1 | High while data is delivered; low means no more data |
| phase | output | 24 | Position readback word |

## Verification
The hardest state to reach is the stop path. The enable must be dropped after buffer 1 has started and before it is found exhausted, and the requests must drain it precisely. The bench first walks a vector table through two full ping-pong laps with enable high, using request sizes that leave partial remainders. It then lowers enable in buffer 0, so it can show that buffer 0 still hands over to buffer 1. Requests then drain buffer 1 until the zero-length, no-more-data answer appears. A restart with a different sample count and an unaligned base follows.

// File: rtl/ppdma_pkg.sv
// Package: shared constants for the ping-pong audio output DMA.
// Assumes an 8-bit control byte with flag bits in [7:6].
package ppdma_pkg;
    localparam int CTL_IE0 = 4;
    localparam int CTL_IE1 = 5;
    localparam int CTL_IF0 = 6;
    localparam int CTL_IF1 = 7;
    localparam logic [7:0] CTL_FLAG_MASK = 8'hC0;
    localparam int PHASE_POS_W = 12;
    localparam int PHASE_PRE_W = 6;
    localparam int PHASE_W = 24;
endpackage

// File: rtl/ppdma_ctrl_reg.sv
// Module: host control/status byte with drain flags and the level interrupt.
// Assumes the set pulses come straight from the pull engine and last one cycle.
module ppdma_ctrl_reg
    import ppdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    input  logic       set_if0,
    input  logic       set_if1,
    output logic [7:0] ctrl_q,
    output logic       irq
);
    logic [7:0] set_vec;

    // Build the flag-set vector from the engine pulses.
    always_comb begin
        set_vec = '0;
        set_vec[CTL_IF0] = set_if0;
        set_vec[CTL_IF1] = set_if1;
    end

    // Store host writes with the flags cleared, then merge newly set flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (host_wr) begin
            ctrl_q <= (host_wdata & ~CTL_FLAG_MASK) | set_vec;
        end else begin
            ctrl_q <= ctrl_q | set_vec;
        end
    end

    // Level interrupt from each flag gated by its enable.
    always_comb begin
        irq = (ctrl_q[CTL_IF0] & ctrl_q[CTL_IE0]) | (ctrl_q[CTL_IF1] & ctrl_q[CTL_IE1]);
    end

    // R7
    wr_clears_if0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !set_if0) |=> !ctrl_q[CTL_IF0]);
    // R7
    wr_clears_if1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !set_if1) |=> !ctrl_q[CTL_IF1]);
    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && ctrl_q[CTL_IF0]) |=> ctrl_q[CTL_IF0]);
endmodule

// File: rtl/ppdma_pull_engine.sv
// Module: buffer index, position and grant calculation for codec pulls.
// Assumes LEN_W >= SAMPLE_W + 2 so every remaining count fits a grant.
module ppdma_pull_engine
    import ppdma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SAMPLE_W   = 10,
    parameter int LEN_W      = 16,
    parameter int ALIGN_BITS = 18,
    parameter logic [ADDR_W-1:0] BUF0_OFFS = 32'h0001_0000,
    parameter logic [ADDR_W-1:0] BUF1_OFFS = 32'h0001_2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              out_en,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [SAMPLE_W-1:0] sample_count,
    input  logic              pull_req,
    input  logic [LEN_W-1:0]  pull_len,
    output logic              resp_valid,
    output logic [ADDR_W-1:0] resp_addr,
    output logic [LEN_W-1:0]  resp_len,
    output logic              resp_more,
    output logic              set_if0,
    output logic              set_if1,
    output logic [PHASE_W-1:0] phase
);
    localparam int POS_W = SAMPLE_W + 2;
    localparam int EXT_W = POS_W + PHASE_POS_W;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W'(1) << ALIGN_BITS) - ADDR_W'(1));

    logic              en_q, run_q, idx_q;
    logic [POS_W-1:0]  pos_q, len_q;
    logic [ADDR_W-1:0] base_q;
    logic              start_evt, exhausted, serve;
    logic              eff_idx, n_idx, n_run;
    logic [POS_W-1:0]  eff_pos, n_pos, rem;
    logic [LEN_W-1:0]  g_len;
    logic [ADDR_W-1:0] g_addr;
    logic              g_more;
    logic [EXT_W-1:0]  pos_ext;

    assign start_evt = out_en && !en_q;
    assign exhausted = (pos_q >= len_q);

    // Decide the grant and the next buffer state for the current request.
    always_comb begin
        n_idx = idx_q; n_pos = pos_q; n_run = run_q;
        eff_idx = idx_q; eff_pos = pos_q; serve = 1'b0;
        set_if0 = 1'b0; set_if1 = 1'b0;
        g_len = '0; g_addr = '0; g_more = 1'b0; rem = '0;
        if (start_evt) begin
            n_idx = 1'b0; n_pos = '0; n_run = 1'b1;
        end else if (pull_req && run_q) begin
            if (exhausted) begin
                set_if0 = !idx_q;
                set_if1 = idx_q;
                if (idx_q && !out_en) begin
                    n_pos = '0; n_run = 1'b0;
                end else begin
                    eff_idx = !idx_q; eff_pos = '0; serve = 1'b1;
                end
            end else begin
                serve = 1'b1;
            end
            if (serve) begin
                rem = len_q - eff_pos;
                g_len = (LEN_W'(rem) < pull_len) ? LEN_W'(rem) : pull_len;
                g_addr = base_q + (eff_idx ? BUF1_OFFS : BUF0_OFFS) + ADDR_W'(eff_pos);
                g_more = 1'b1;
                n_idx = eff_idx;
                n_pos = eff_pos + POS_W'(g_len);
            end
        end
    end

    // Register buffer state, latched configuration and the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0; run_q <= 1'b0; idx_q <= 1'b0;
            pos_q <= '0; len_q <= '0; base_q <= '0;
            resp_valid <= 1'b0; resp_addr <= '0; resp_len <= '0; resp_more <= 1'b0;
        end else begin
            en_q <= out_en;
            run_q <= n_run; idx_q <= n_idx; pos_q <= n_pos;
            if (start_evt) begin
                base_q <= base_addr & ALIGN_MASK;
                len_q <= {sample_count, 2'b00};
            end
            resp_valid <= pull_req;
            resp_addr <= g_addr;
            resp_len <= g_len;
            resp_more <= g_more;
        end
    end

    // Place the low position bits into the phase word.
    always_comb begin
        pos_ext = EXT_W'(pos_q);
        phase = {{(PHASE_W-PHASE_POS_W-PHASE_PRE_W){1'b0}}, pos_ext[PHASE_POS_W-1:0], {PHASE_PRE_W{1'b0}}};
    end

    // R3
    grant_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> resp_len <= $past(pull_len));
    // R3
    pos_in_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= len_q);
    // R2
    start_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (pos_q == '0 && !idx_q && run_q));
    // R4
    one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_if0, set_if1}));
    // R5
    nomore_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_more) |-> resp_len == '0);
endmodule

// File: rtl/pp_audio_dma.sv
// Module: top of the ping-pong audio output DMA.
// Joins the pull engine and the control byte; assumes one codec requester.
module pp_audio_dma
    import ppdma_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SAMPLE_W = 10,
    parameter int LEN_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                out_en,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [SAMPLE_W-1:0] sample_count,
    input  logic                host_wr,
    input  logic [7:0]          host_wdata,
    output logic [7:0]          host_rdata,
    output logic                irq,
    input  logic                pull_req,
    input  logic [LEN_W-1:0]    pull_len,
    output logic                resp_valid,
    output logic [ADDR_W-1:0]   resp_addr,
    output logic [LEN_W-1:0]    resp_len,
    output logic                resp_more,
    output logic [PHASE_W-1:0]  phase
);
    logic set_if0, set_if1;

    ppdma_pull_engine #(
        .ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W), .LEN_W(LEN_W)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .out_en(out_en),
        .base_addr(base_addr), .sample_count(sample_count),
        .pull_req(pull_req), .pull_len(pull_len),
        .resp_valid(resp_valid), .resp_addr(resp_addr),
        .resp_len(resp_len), .resp_more(resp_more),
        .set_if0(set_if0), .set_if1(set_if1), .phase(phase)
    );

    ppdma_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .set_if0(set_if0), .set_if1(set_if1),
        .ctrl_q(host_rdata), .irq(irq)
    );
endmodule

// File: tb/pp_audio_dma_bench.sv
module pp_audio_dma_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic out_en = 1'b0;
    logic [31:0] base_addr = '0;
    logic [9:0]  sample_count = '0;
    logic host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic irq;
    logic pull_req = 1'b0;
    logic [15:0] pull_len = '0;
    logic resp_valid, resp_more;
    logic [31:0] resp_addr;
    logic [15:0] resp_len;
    logic [23:0] phase;
    int n_tests = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pp_audio_dma u_pp_audio_dma (
        .clk(clk), .rst_n(rst_n), .out_en(out_en), .base_addr(base_addr),
        .sample_count(sample_count), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq), .pull_req(pull_req), .pull_len(pull_len),
        .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_len(resp_len),
        .resp_more(resp_more), .phase(phase)
    );

    // Ping-pong laps with 12-byte buffers, buf0 = 0x12350000, buf1 = 0x12352000
    localparam int NV = 6;
    localparam logic [15:0] V_REQ  [NV] = '{16'd5, 16'd10, 16'd4, 16'd8, 16'd3, 16'd9};
    localparam logic [15:0] V_LEN  [NV] = '{16'd5, 16'd7, 16'd4, 16'd8, 16'd3, 16'd9};
    localparam logic [31:0] V_ADDR [NV] = '{32'h1235_0000, 32'h1235_0005, 32'h1235_2000,
                                            32'h1235_2004, 32'h1235_0000, 32'h1235_0003};
    localparam logic [23:0] V_PH   [NV] = '{24'h140, 24'h300, 24'h100, 24'h300, 24'h0C0, 24'h300};

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic pull(input logic [15:0] len);
        @(negedge clk); pull_req = 1'b1; pull_len = len;
        @(negedge clk); pull_req = 1'b0;
    endtask

    task automatic hwrite(input logic [7:0] v);
        @(negedge clk); host_wr = 1'b1; host_wdata = v;
        @(negedge clk); host_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ctrl", 32'(host_rdata), 32'h00);
        check("R1 irq", 32'(irq), 32'd0);
        check("R1 phase", 32'(phase), 32'd0);
        check("R1 valid", 32'(resp_valid), 32'd0);
        // R6: pull before any start
        pull(16'd4);
        check("R6 valid", 32'(resp_valid), 32'd1);
        check("R6 len", 32'(resp_len), 32'd0);
        check("R6 more", 32'(resp_more), 32'd0);
        check("R6 ctrl", 32'(host_rdata), 32'h00);
        hwrite(8'h10);
        base_addr = 32'h1234_5678; sample_count = 10'd3;
        @(negedge clk); out_en = 1'b1;
        @(negedge clk);
        check("R2 phase at start", 32'(phase), 32'd0);
        for (int i = 0; i < NV; i++) begin
            pull(V_REQ[i]);
            check("R3 len", 32'(resp_len), 32'(V_LEN[i]));
            check("R3 addr", resp_addr, V_ADDR[i]);
            check("R3 more", 32'(resp_more), 32'd1);
            check("R9 phase", 32'(phase), 32'(V_PH[i]));
        end
        // R4: both drain flags set during the laps, R8 IF0&IE0
        check("R4 flags", 32'(host_rdata), 32'hD0);
        check("R8 irq on", 32'(irq), 32'd1);
        hwrite(8'hF0);
        check("R7 write clears flags", 32'(host_rdata), 32'h30);
        check("R8 irq off", 32'(irq), 32'd0);
        hwrite(8'h20);
        // R5: enable low in buffer 0 still hands over to buffer 1
        @(negedge clk); out_en = 1'b0;
        pull(16'd2);
        check("R5 hand-over addr", resp_addr, 32'h1235_2000);
        check("R5 hand-over len", 32'(resp_len), 32'd2);
        check("R8 masked IF0", 32'(irq), 32'd0);
        check("R4 IF0 bit6", 32'(host_rdata), 32'h60);
        pull(16'd20);
        check("R3 clipped len", 32'(resp_len), 32'd10);
        pull(16'd1);
        check("R5 stop len", 32'(resp_len), 32'd0);
        check("R5 stop more", 32'(resp_more), 32'd0);
        check("R5 phase reset", 32'(phase), 32'd0);
        check("R8 IF1 irq", 32'(irq), 32'd1);
        check("R4 IF1 bit7", 32'(host_rdata), 32'hE0);
        pull(16'd1);
        check("R6 stopped len", 32'(resp_len), 32'd0);
        check("R6 stopped more", 32'(resp_more), 32'd0);
        check("R6 ctrl kept", 32'(host_rdata), 32'hE0);
        // R7: flag set in the same cycle as a host write survives
        hwrite(8'h00);
        base_addr = 32'h0007_FFFF; sample_count = 10'd1;
        @(negedge clk); out_en = 1'b1;
        @(negedge clk);
        pull(16'd8);
        check("R2 aligned addr", resp_addr, 32'h0005_0000);
        check("R2 len x4", 32'(resp_len), 32'd4);
        @(negedge clk); pull_req = 1'b1; pull_len = 16'd1; host_wr = 1'b1; host_wdata = 8'hC1;
        @(negedge clk); pull_req = 1'b0; host_wr = 1'b0;
        check("R7 same-cycle flag", 32'(host_rdata), 32'h41);
        check("R4 toggle addr", resp_addr, 32'h0005_2000);
        // R2: start edge with a request in the same cycle
        @(negedge clk); out_en = 1'b0;
        @(negedge clk); out_en = 1'b1; pull_req = 1'b1; pull_len = 16'd3;
        @(negedge clk); pull_req = 1'b0;
        check("R2 start-cycle len", 32'(resp_len), 32'd0);
        check("R2 start-cycle more", 32'(resp_more), 32'd0);
        pull(16'd3);
        check("R2 restart addr", resp_addr, 32'h0005_0000);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule